// File: doc/BRIEF.md
# Low-Side Channel Fault Supervisor

This block watches over a single low-side power switch channel. The channel takes an active-low drive command and three digitized comparator flags. One flag reports over-current, one reports load current below the open-load level, and one reports output voltage below the ground-short level. From these the block produces the registered gate-enable that actually turns the switch on. It also keeps three sticky fault bits: short-circuit, open-load and short-to-ground.

Each fault is judged only in the drive state where it means something. A ground short is only looked for while the switch is off. An open load is only looked for while the switch is on. Over-current is only looked for while the switch is on, and it must persist through a filter before anything happens. A confirmed short circuit switches the output off and holds it off until the drive command is released and applied again. All delays are counted in ticks of one shared prescaled timebase. Each persistence counter starts again from zero whenever its condition drops.

The sticky bits are cleared by a one-cycle strobe from the diagnostic read path. Synchronous reset or a low-supply indication forces the switch off and clears every counter and bit. Instances for the high-current channels enable the threshold-select variant, which chooses between two over-current comparators.

Top module: `chan_fault_sup`

## Requirements
- R1: With no lockout and no hold, `gate_en` equals the inverse of `drive_n` one clock later. Low on `drive_n` means on.
- R2: Comparator flags pass through two flip-flops. Over-current is judged only while `gate_en` is 1. If it stays present for SC_TICKS consecutive timebase ticks, `sc_flag` sets and `gate_en` drops in the same cycle. A shorter burst has no effect.
- R3: After a short-circuit trip, `gate_en` stays 0 while `drive_n` stays low, even if the over-current goes away. One cycle of `drive_n` high followed by low turns the output on again.
- R4: Open-load is judged only while `gate_en` is 1. If the flag persists while the output is off, `ol_flag` never sets.
- R5: When `ol_short_sel` is 1, the open-load persistence is OL_SHORT_TICKS ticks. When it is 0 (the reset value a host would program), it is OL_LONG_TICKS ticks.
- R6: Short-to-ground is judged only while `gate_en` is 0, with a persistence of SG_TICKS ticks. A low output voltage while the output is on never sets `sg_flag`.
- R7: With HAS_ILIM_SEL=1, `ilim_sel_lo`=1 makes `oc_lo_raw` the over-current source (lower threshold) and `ilim_sel_lo`=0 makes `oc_hi_raw` the source. Without the variant, `oc_hi_raw` is always the source.
- R8: While `rst` or `low_supply` is 1, `gate_en` and all three fault bits are 0 on the next clock, and all counters and the timebase restart.
- R9: A cycle of `diag_clr` clears all three fault bits on the next clock and restarts the persistence counters. A fault that is still present sets its bit again only after its full persistence time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| low_supply | input | 1 | Low-supply indication; holds the channel off and cleared |
| drive_n | input | 1 | Active-low drive command |
| oc_hi_raw | input | 1 | Over-current flag, high threshold (asynchronous) |
| oc_lo_raw | input | 1 | Over-current flag, low threshold (asynchronous) |
| ilim_sel_lo | input | 1 | 1 selects the low over-current threshold |
| ol_raw | input | 1 | Load current below open-load level (asynchronous) |
| ol_short_sel | input | 1 | 1 selects the short open-load delay |
| sg_raw | input | 1 | Output voltage below ground-short level (asynchronous) |
| diag_clr | input | 1 | One-cycle clear strobe for the sticky fault bits |
| gate_en | output | 1 | Registered gate-drive enable |
| sc_flag | output | 1 | Sticky short-circuit fault bit |
| ol_flag | output | 1 | Sticky open-load fault bit |
| sg_flag | output | 1 | Sticky short-to-ground fault bit |

## Verification
The bench sends an over-current burst shorter than two tick periods. A design that failed to restart its counter when the condition drops, or that skipped the filter, would latch a short circuit here. It holds the over-current away after a trip while the drive command stays low. A design that released the lockout on fault removal, rather than on a drive toggle, would turn the switch back on. Low-voltage and low-current flags are applied in the opposite drive state; a design that did not gate detection by drive state would report false faults. The bench also clears a fault whose condition is still present and checks that the bit stays low for most of the persistence window. A design that kept its counter running through the clear would set the bit again too early.

// File: rtl/fsup_pkg.sv
package fsup_pkg;
  localparam int NUM_FLT = 3;
  localparam int FLT_SC  = 0;
  localparam int FLT_OL  = 1;
  localparam int FLT_SG  = 2;
  typedef logic [NUM_FLT-1:0] flt_vec_t;

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction
endpackage

// File: rtl/fsup_sync2.sv
module fsup_sync2 #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] meta_q;
  logic [W-1:0] stab_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '0;
      stab_q <= '0;
    end else begin
      meta_q <= din;
      stab_q <= meta_q;
    end
  end

  assign dout = stab_q;
endmodule

// File: rtl/fsup_timebase.sv
module fsup_timebase #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
  logic [PW-1:0] pre_q;

  assign tick = (pre_q == PW'(DIV - 1));

  always_ff @(posedge clk) begin
    if (rst)       pre_q <= '0;
    else if (tick) pre_q <= '0;
    else           pre_q <= pre_q + PW'(1);
  end
endmodule

// File: rtl/fsup_persist.sv
module fsup_persist #(
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          cond,
  input  logic          clr,
  input  logic [CW-1:0] lim,
  output logic          expire
);
  logic [CW-1:0] cnt_q;

  assign expire = cond & tick & ~clr & (cnt_q >= (lim - CW'(1)));

  always_ff @(posedge clk) begin
    if (rst)                           cnt_q <= '0;
    else if (!cond || clr || expire)   cnt_q <= '0;
    else if (tick)                     cnt_q <= cnt_q + CW'(1);
  end
endmodule

// File: rtl/chan_fault_sup.sv
module chan_fault_sup
  import fsup_pkg::*;
#(
  parameter int TICK_DIV       = 4,
  parameter int SC_TICKS       = 2,
  parameter int OL_LONG_TICKS  = 16,
  parameter int OL_SHORT_TICKS = 4,
  parameter int SG_TICKS       = 6,
  parameter bit HAS_ILIM_SEL   = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic low_supply,
  input  logic drive_n,
  input  logic oc_hi_raw,
  input  logic oc_lo_raw,
  input  logic ilim_sel_lo,
  input  logic ol_raw,
  input  logic ol_short_sel,
  input  logic sg_raw,
  input  logic diag_clr,
  output logic gate_en,
  output logic sc_flag,
  output logic ol_flag,
  output logic sg_flag
);
  localparam int MAX_T = max3(SC_TICKS, max3(OL_LONG_TICKS, OL_SHORT_TICKS, 1), SG_TICKS);
  localparam int CW    = $clog2(MAX_T + 1);

  logic       hold;
  logic       tick;
  logic [3:0] raw_v;
  logic [3:0] syn_v;
  logic       sel_eff;
  logic       oc_pick;
  logic       gate_q;
  logic       lock_q;
  logic       lock_nxt;
  flt_vec_t   cond_v;
  flt_vec_t   exp_v;
  flt_vec_t   flags_q;
  logic [CW-1:0] lim_v [NUM_FLT];

  assign hold  = rst | low_supply;
  assign raw_v = {sg_raw, ol_raw, oc_lo_raw, oc_hi_raw};

  fsup_sync2 #(.W(4)) u_sync (
    .clk (clk),
    .rst (hold),
    .din (raw_v),
    .dout(syn_v)
  );

  fsup_timebase #(.DIV(TICK_DIV)) u_tb (
    .clk (clk),
    .rst (hold),
    .tick(tick)
  );

  generate
    if (HAS_ILIM_SEL) begin : g_isel
      assign sel_eff = ilim_sel_lo;
    end else begin : g_fixed
      assign sel_eff = 1'b0;
    end
  endgenerate

  assign oc_pick = sel_eff ? syn_v[1] : syn_v[0];

  assign cond_v[FLT_SC] = gate_q & oc_pick;
  assign cond_v[FLT_OL] = gate_q & syn_v[2];
  assign cond_v[FLT_SG] = ~gate_q & syn_v[3];

  assign lim_v[FLT_SC] = CW'(SC_TICKS);
  assign lim_v[FLT_OL] = ol_short_sel ? CW'(OL_SHORT_TICKS) : CW'(OL_LONG_TICKS);
  assign lim_v[FLT_SG] = CW'(SG_TICKS);

  generate
    for (genvar j = 0; j < NUM_FLT; j++) begin : g_flt
      fsup_persist #(.CW(CW)) u_pers (
        .clk   (clk),
        .rst   (hold),
        .tick  (tick),
        .cond  (cond_v[j]),
        .clr   (diag_clr),
        .lim   (lim_v[j]),
        .expire(exp_v[j])
      );
    end
  endgenerate

  assign lock_nxt = drive_n ? 1'b0 : (lock_q | exp_v[FLT_SC]);

  always_ff @(posedge clk) begin
    if (hold) begin
      lock_q  <= 1'b0;
      gate_q  <= 1'b0;
      flags_q <= '0;
    end else begin
      lock_q  <= lock_nxt;
      gate_q  <= ~drive_n & ~lock_nxt;
      flags_q <= diag_clr ? '0 : (flags_q | exp_v);
    end
  end

  assign gate_en = gate_q;
  assign sc_flag = flags_q[FLT_SC];
  assign ol_flag = flags_q[FLT_OL];
  assign sg_flag = flags_q[FLT_SG];
endmodule

// File: rtl/fsup_checker.sv
module fsup_checker (
  input logic clk,
  input logic rst,
  input logic low_supply,
  input logic drive_n,
  input logic diag_clr,
  input logic gate_en,
  input logic sc_flag,
  input logic ol_flag,
  input logic sg_flag
);
  assert_gate_needs_cmd_R1: assert property (@(posedge clk) disable iff (rst)
    gate_en |-> !$past(drive_n));

  assert_sc_trip_off_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(sc_flag) |-> !gate_en);

  assert_ol_only_on_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(ol_flag) |-> $past(gate_en));

  assert_sg_only_off_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(sg_flag) |-> !$past(gate_en));

  assert_hold_clears_R8: assert property (@(posedge clk) disable iff (rst)
    low_supply |=> (!gate_en && !sc_flag && !ol_flag && !sg_flag));

  assert_clear_strobe_R9: assert property (@(posedge clk) disable iff (rst || low_supply)
    diag_clr |=> (!sc_flag && !ol_flag && !sg_flag));
endmodule

bind chan_fault_sup fsup_checker u_fsup_checker (
  .clk       (clk),
  .rst       (rst),
  .low_supply(low_supply),
  .drive_n   (drive_n),
  .diag_clr  (diag_clr),
  .gate_en   (gate_en),
  .sc_flag   (sc_flag),
  .ol_flag   (ol_flag),
  .sg_flag   (sg_flag)
);

// File: tb/chan_fault_sup_bench.sv
`timescale 1ns/1ps
module chan_fault_sup_bench;
  localparam int DIV = 4, SCT = 2, OLL = 16, OLS = 4, SGT = 6;

  logic clk = 1'b0;
  logic rst = 1'b1, low_supply = 1'b0, drive_n = 1'b1;
  logic oc_hi_raw = 1'b0, oc_lo_raw = 1'b0, ilim_sel_lo = 1'b0;
  logic ol_raw = 1'b0, ol_short_sel = 1'b0, sg_raw = 1'b0, diag_clr = 1'b0;
  logic gate_en, sc_flag, ol_flag, sg_flag;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  chan_fault_sup u_chan_fault_sup (
    .clk(clk), .rst(rst), .low_supply(low_supply), .drive_n(drive_n),
    .oc_hi_raw(oc_hi_raw), .oc_lo_raw(oc_lo_raw), .ilim_sel_lo(ilim_sel_lo),
    .ol_raw(ol_raw), .ol_short_sel(ol_short_sel), .sg_raw(sg_raw),
    .diag_clr(diag_clr), .gate_en(gate_en), .sc_flag(sc_flag),
    .ol_flag(ol_flag), .sg_flag(sg_flag)
  );

  // behavioural reference model
  int  m_pre;
  int  m_cnt [3];
  bit  m_s1 [4];
  bit  m_s2 [4];
  bit  m_gate, m_lock, m_sc, m_ol, m_sg;

  always @(posedge clk) begin
    bit tk, c[3], ex[3];
    int lim[3];
    cycles++;
    if (rst || low_supply) begin
      m_pre = 0; m_gate = 0; m_lock = 0; m_sc = 0; m_ol = 0; m_sg = 0;
      for (int i = 0; i < 3; i++) m_cnt[i] = 0;
      for (int i = 0; i < 4; i++) begin m_s1[i] = 0; m_s2[i] = 0; end
    end else begin
      tk = (m_pre == DIV - 1);
      m_pre = tk ? 0 : m_pre + 1;
      c[0] = m_gate && (ilim_sel_lo ? m_s2[1] : m_s2[0]);
      c[1] = m_gate && m_s2[2];
      c[2] = !m_gate && m_s2[3];
      lim[0] = SCT; lim[1] = ol_short_sel ? OLS : OLL; lim[2] = SGT;
      for (int i = 0; i < 3; i++) begin
        ex[i] = c[i] && tk && !diag_clr && (m_cnt[i] >= lim[i] - 1);
        if (!c[i] || diag_clr || ex[i]) m_cnt[i] = 0;
        else if (tk) m_cnt[i] = m_cnt[i] + 1;
      end
      m_lock = drive_n ? 0 : (m_lock || ex[0]);
      m_gate = !drive_n && !m_lock;
      if (diag_clr) begin m_sc = 0; m_ol = 0; m_sg = 0; end
      else begin m_sc |= ex[0]; m_ol |= ex[1]; m_sg |= ex[2]; end
      for (int i = 0; i < 4; i++) m_s2[i] = m_s1[i];
      m_s1[0] = oc_hi_raw; m_s1[1] = oc_lo_raw; m_s1[2] = ol_raw; m_s1[3] = sg_raw;
    end
  end

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b t=%0t", req, act, exp, $time);
    end
  endtask

  // cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst) begin
      chk("R1 model gate_en", gate_en, m_gate);
      chk("R2 model sc_flag", sc_flag, m_sc);
      chk("R4 model ol_flag", ol_flag, m_ol);
      chk("R6 model sg_flag", sg_flag, m_sg);
    end
  end

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    if (cycles > 20000) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clear_pulse();
    diag_clr = 1'b1; step(1); diag_clr = 1'b0;
  endtask

  initial begin
    step(3);
    chk("R8 reset gate", gate_en, 1'b0);
    chk("R8 reset sc", sc_flag, 1'b0);
    rst = 1'b0;
    step(2);

    // R1 drive polarity
    drive_n = 1'b0; step(1);
    chk("R1 on", gate_en, 1'b1);
    drive_n = 1'b1; step(1);
    chk("R1 off", gate_en, 1'b0);

    // R6 ground short only while off
    drive_n = 1'b0; sg_raw = 1'b1; step(60);
    chk("R6 ignored while on", sg_flag, 1'b0);
    drive_n = 1'b1; step(40);
    chk("R6 set while off", sg_flag, 1'b1);
    sg_raw = 1'b0; step(3); clear_pulse();
    chk("R9 clear", sg_flag, 1'b0);

    // R4/R5 open load, short delay
    ol_short_sel = 1'b1; drive_n = 1'b0; ol_raw = 1'b1; step(30);
    chk("R5 short delay set", ol_flag, 1'b1);
    ol_raw = 1'b0; step(3); clear_pulse();
    ol_short_sel = 1'b0; ol_raw = 1'b1; step(30);
    chk("R5 long delay not yet", ol_flag, 1'b0);
    step(60);
    chk("R5 long delay set", ol_flag, 1'b1);
    drive_n = 1'b1; step(2); clear_pulse(); step(100);
    chk("R4 ignored while off", ol_flag, 1'b0);
    ol_raw = 1'b0; step(3);

    // R9 condition still present after clear
    sg_raw = 1'b1; step(40);
    chk("R9 pre", sg_flag, 1'b1);
    clear_pulse();
    chk("R9 cleared", sg_flag, 1'b0);
    step(10);
    chk("R9 full time again", sg_flag, 1'b0);
    step(30);
    chk("R9 set again", sg_flag, 1'b1);
    sg_raw = 1'b0; step(3); clear_pulse();

    // R2 filter and trip, R3 lockout
    drive_n = 1'b0; step(3);
    oc_hi_raw = 1'b1; step(3); oc_hi_raw = 1'b0; step(20);
    chk("R2 short burst ignored", sc_flag, 1'b0);
    chk("R2 gate stays on", gate_en, 1'b1);
    oc_hi_raw = 1'b1; step(30);
    chk("R2 trip flag", sc_flag, 1'b1);
    chk("R2 trip off", gate_en, 1'b0);
    oc_hi_raw = 1'b0; step(10);
    chk("R3 locked", gate_en, 1'b0);
    drive_n = 1'b1; step(1); drive_n = 1'b0; step(2);
    chk("R3 restored", gate_en, 1'b1);
    clear_pulse();

    // R7 threshold select
    ilim_sel_lo = 1'b0; oc_lo_raw = 1'b1; step(40);
    chk("R7 low thr unselected", sc_flag, 1'b0);
    ilim_sel_lo = 1'b1; step(40);
    chk("R7 low thr selected", sc_flag, 1'b1);
    chk("R7 trip off", gate_en, 1'b0);
    oc_lo_raw = 1'b0; ilim_sel_lo = 1'b0; drive_n = 1'b1; step(3); clear_pulse();

    // R8 low supply hold
    drive_n = 1'b0; ol_short_sel = 1'b1; ol_raw = 1'b1; step(30);
    chk("R8 pre ol", ol_flag, 1'b1);
    low_supply = 1'b1; step(1);
    chk("R8 gate off", gate_en, 1'b0);
    chk("R8 ol cleared", ol_flag, 1'b0);
    ol_raw = 1'b0; low_supply = 1'b0; step(2);
    chk("R8 resume", gate_en, 1'b1);
    step(5);
    summary();
  end
endmodule